// File: doc/BRIEF.md
# Cascadable Borrow-Flag Magnitude Comparator

This block compares two unsigned operands and raises exactly one of three flags: greater, less or equal. The operands are split into 4-bit slices. Each slice runs two opposing subtractions on its own nibbles, first minus second and second minus first. It discards both differences and keeps only the two no-borrow flags.

The two flags settle along parallel paths, so the three slice outcomes become valid together. The design never subtracts first and then tests the difference for zero. Slices are chained from least to most significant. Each slice receives the less/equal/greater verdict of the slices below it as a one-hot cascade input. When its own nibbles differ, a slice overrides that verdict. When its nibbles are equal, it passes the verdict through unchanged. The lowest slice is seeded with "equal so far".

The block is purely combinational and has no clock. The number of slices is a parameter, and the default of two gives an 8-bit compare.

Top module: `mag_cmp_chain`

## Requirements
- R1: `eq_o` is 1 exactly when `lhs_i` equals `rhs_i`.
- R2: `gt_o` is 1 exactly when `lhs_i` is greater than `rhs_i`, with both read as unsigned.
- R3: `lt_o` is 1 exactly when `lhs_i` is less than `rhs_i`, with both read as unsigned.
- R4: For every operand pair, exactly one of `gt_o`, `lt_o` and `eq_o` is 1.
- R5: When the upper nibbles (bits [7:4]) differ, they alone decide the result, whatever the lower nibbles hold.
- R6: When the upper nibbles are equal, the result is the verdict of the lower nibbles (bits [3:0]).
- R7: The lowest slice starts from a neutral equal state, so two all-zero operands give `eq_o` = 1.
- R8: The outputs have no register: they follow a new operand pair within the same cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_i | input | 8 (4·SLICES) | First unsigned operand |
| rhs_i | input | 8 (4·SLICES) | Second unsigned operand |
| gt_o | output | 1 | First operand is greater |
| lt_o | output | 1 | First operand is less |
| eq_o | output | 1 | Operands are equal |

## Verification
The bench sweeps every one of the 65,536 operand pairs and applies a new pair each cycle. This sweep separates the greater, less and equal cases and catches any pair in which the flags are not one-hot. Directed pairs with differing upper nibbles and an opposing lower-nibble relation show whether the upper slice overrides its cascade input. Pairs with equal upper nibbles show whether the lower verdict is passed through. The all-zero pair shows that the chain is seeded to the neutral equal state.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/borrow_sub.sv
module borrow_sub #(
  parameter int W = 4
) (
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] sub_i,
  output logic         nb_o
);
  // Ripple carry of min + ~sub + 1; the final carry is the no-borrow flag.
  logic [W:0] cy;

  always_comb begin
    cy[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      cy[i+1] = (min_i[i] & ~sub_i[i]) | ((min_i[i] | ~sub_i[i]) & cy[i]);
    end
  end

  assign nb_o = cy[W];
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  rel_t         casc_i,
  output rel_t         res_o
);
  logic nb_xy;
  logic nb_yx;
  rel_t local_rel;

  // Two opposing subtractions evaluated side by side.
  borrow_sub #(.W(W)) u_sub_xy (.min_i(x_i), .sub_i(y_i), .nb_o(nb_xy));
  borrow_sub #(.W(W)) u_sub_yx (.min_i(y_i), .sub_i(x_i), .nb_o(nb_yx));

  always_comb begin
    local_rel.gt = nb_xy & ~nb_yx;
    local_rel.lt = nb_yx & ~nb_xy;
    local_rel.eq = nb_xy & nb_yx;
  end

  // The slice's own difference overrides the verdict from below.
  always_comb begin
    if (local_rel.eq) res_o = casc_i;
    else              res_o = local_rel;
  end

  always_comb begin
    // R1: both subtractions cannot borrow at once
    assert_nb_cover_R1: assert (nb_xy | nb_yx);
    // R4: one-hot cascade input gives one-hot slice output
    if ($onehot({casc_i.gt, casc_i.eq, casc_i.lt}))
      assert_slice_onehot_R4: assert ($onehot({res_o.gt, res_o.eq, res_o.lt}));
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int SLICES  = 2,
  parameter int SLICE_W = 4
) (
  input  logic [SLICES*SLICE_W-1:0] lhs_i,
  input  logic [SLICES*SLICE_W-1:0] rhs_i,
  output logic                      gt_o,
  output logic                      lt_o,
  output logic                      eq_o
);
  localparam int WIDTH = SLICES * SLICE_W;

  rel_t link [SLICES+1];

  assign link[0] = REL_EQ;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) u_slice (
      .x_i    (lhs_i[s*SLICE_W +: SLICE_W]),
      .y_i    (rhs_i[s*SLICE_W +: SLICE_W]),
      .casc_i (link[s]),
      .res_o  (link[s+1])
    );
  end

  assign gt_o = link[SLICES].gt;
  assign lt_o = link[SLICES].lt;
  assign eq_o = link[SLICES].eq;

  always_comb begin
    assert_eq_match_R1: assert (eq_o == (lhs_i == rhs_i));
    assert_gt_match_R2: assert (gt_o == (lhs_i > rhs_i));
    assert_lt_match_R3: assert (lt_o == (lhs_i < rhs_i));
    assert_onehot_out_R4: assert ($onehot({gt_o, lt_o, eq_o}));
    if (WIDTH > 0 && lhs_i == '0 && rhs_i == '0)
      assert_seed_eq_R7: assert (eq_o);
  end
endmodule

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       gt;
    logic       lt;
    logic       eq;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lhs = '0;
  logic [7:0] rhs = '0;
  logic       gt_o, lt_o, eq_o;

  int checks = 0;
  int errors = 0;
  bit drv_done = 1'b0;
  bit finished = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  mag_cmp_chain u_mag_cmp_chain (
    .lhs_i (lhs),
    .rhs_i (rhs),
    .gt_o  (gt_o),
    .lt_o  (lt_o),
    .eq_o  (eq_o)
  );

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    lhs = a;
    rhs = b;
    it.a = a; it.b = b;
    it.gt = (a > b); it.lt = (a < b); it.eq = (a == b);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(8'h00, 8'h00, "R7");
    drive(8'h50, 8'h4F, "R5");
    drive(8'h4F, 8'h50, "R5");
    drive(8'hA0, 8'h9F, "R5");
    drive(8'h37, 8'h39, "R6");
    drive(8'h39, 8'h37, "R6");
    drive(8'h6C, 8'h6C, "R6");
    drive(8'hFF, 8'hFF, "R1");
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive(a[7:0], b[7:0], "R8");
      end
    end
    drv_done = 1'b1;
  end

  // Monitor
  initial begin
    item_t it;
    string rq;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        rq = it.eq ? "R1" : (it.gt ? "R2" : "R3");
        checks++;
        if ({gt_o, lt_o, eq_o} != {it.gt, it.lt, it.eq}) begin
          errors++;
          $display("FAIL %s/%s a=%02h b=%02h got gt/lt/eq=%b%b%b exp=%b%b%b",
                   it.tag, rq, it.a, it.b, gt_o, lt_o, eq_o, it.gt, it.lt, it.eq);
        end
        checks++;
        if (!$onehot({gt_o, lt_o, eq_o})) begin
          errors++;
          $display("FAIL R4 a=%02h b=%02h got flags=%b%b%b exp one-hot",
                   it.a, it.b, gt_o, lt_o, eq_o);
        end
      end else if (drv_done && !finished) begin
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule